// File: doc/BRIEF.md
# Photovoltaic Boost Converter Averaged-Model Stepper

This block advances a discrete-time averaged model of a boost stage fed by a solar panel. It runs one model step for each step strobe. A step reads the source current of the panel from a curve table indexed by the present panel voltage. It then computes the new panel (input capacitor) voltage and the new inductor current from the values held before the step. Last, it derives the current that the diode passes to the bus. The duty command and the bus voltage come from outside the block, from a controller model and a bus model, and are captured when the strobe is accepted.

Every quantity uses fixed point. Voltages and currents carry 8 fraction bits (1 LSB = 1/256 V or 1/256 A) in 16-bit words. The duty word has 10 bits, with D = duty/1024. The model constants are Q16 numbers derived from a 28 µs step, a 330 µF input capacitor, a 110 µH inductor and 0.4 Ω of series resistance.

A four-state machine controls the step:
- S_IDLE waits for the strobe. On the strobe it moves to S_LOAD and captures the duty and bus voltage.
- S_LOAD registers the table current and moves to S_CALC.
- S_CALC registers the next panel voltage and inductor current and moves to S_COMMIT.
- S_COMMIT writes all three states together, pulses done and returns to S_IDLE.

Top module: `boost_avg_emu`

## Requirements
- R1: While reset is high, the panel voltage, inductor current and diode current outputs are 0 and step_done is 0.
- R2: The strobe is accepted only in S_IDLE, and a strobe seen in any other state is ignored. After an accepted strobe, the states change at the third following clock edge. step_done is high for exactly that one cycle, and the outputs stay unchanged at every other time.
- R3: Panel voltage update: vpv' = vpv + ((ipv − iL)·5561 >>> 16), with arithmetic (floor) shift.
- R4: Inductor update: iL' = ((iL·58863) >>> 16) + (((vpv − ((vbus·(1024−Dq)) >> 10))·16682) >>> 16).
- R5: If the R4 result is below zero, the inductor current is stored as 0.
- R6: A captured duty word above 972 is used as 972, so 1−D never falls below 52/1024.
- R7: Diode current: iP' = (iL'·(1024−Dq)) >> 10, where iL' is the current after R5.
- R8: The table index is (vpv·7003) >> 16. A negative voltage gives index 0 and an index above 1023 gives 1023. For an index n below 820 the entry is 2260 − (133·n)/820, and for other n it is 2127·(1023−n)/203 (integer division).
- R9: R3 and R4 both use the states from before the step, so the new panel voltage does not feed the same step's inductor update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Step strobe |
| duty | input | 10 | Duty command, D = duty/1024 |
| vbus | input | 16 | Bus voltage, unsigned, 1/256 V |
| vpv_o | output | 16 | Panel voltage, signed, 1/256 V |
| il_o | output | 16 | Inductor current, signed, 1/256 A |
| ip_o | output | 16 | Diode current, signed, 1/256 A |
| step_done | output | 1 | One-cycle pulse when new states are valid |

## Verification
The assertions check on every cycle that done lasts a single cycle and comes only out of S_COMMIT. They also check that the outputs hold still when no step completes, that the stored inductor current is never negative, and that the captured duty never exceeds its ceiling. The arithmetic of each step cannot be seen by a property. Only the bench's reference model can show it, by comparing the rounding of R3, R4 and R7, the table shape and index clamping at both ends, saturated duty, and strobes held through busy states against the outputs on every clock.

// File: rtl/boost_pkg.sv
package boost_pkg;
    localparam int VAL_W      = 16;
    localparam int DUTY_W     = 10;
    localparam int TBL_DEPTH  = 1024;
    localparam int COEF_SH    = 16;
    localparam int K_CAP      = 5561;   // T/Cpv in Q16
    localparam int K_IND      = 16682;  // T/Lp in Q16
    localparam int K_RES      = 58863;  // 1 - rp*T/Lp in Q16
    localparam int K_IDX      = 7003;   // 1023/37.4V per Q8 volt, Q16
    localparam int DUTY_CEIL  = 972;
    localparam int ISC_Q      = 2260;
    localparam int IMP_Q      = 2127;
    localparam int KNEE_IDX   = 820;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LOAD,
        S_CALC,
        S_COMMIT
    } step_state_t;

    function automatic int pv_curve(input int n, input int depth, input int knee,
                                    input int isc, input int imp);
        if (n < knee)
            return isc - ((isc - imp) * n) / knee;
        return (imp * (depth - 1 - n)) / (depth - 1 - knee);
    endfunction
endpackage

// File: rtl/boost_pv_lut.sv
module boost_pv_lut
    import boost_pkg::*;
#(
    parameter int VW    = VAL_W,
    parameter int DEPTH = TBL_DEPTH,
    parameter int KIDX  = K_IDX,
    parameter int SH    = COEF_SH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd_en,
    input  logic signed [VW-1:0] vpv,
    output logic        [VW-1:0] ipv
);
    localparam int AW = $clog2(DEPTH);

    logic        [VW-1:0] curve_rom [DEPTH];
    logic signed [31:0]   scaled;
    logic signed [31:0]   raw_idx;
    logic        [AW-1:0] idx;

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign curve_rom[g] = VW'(pv_curve(g, DEPTH, KNEE_IDX, ISC_Q, IMP_Q));
    end

    always_comb begin
        scaled  = 32'(vpv) * 32'(KIDX);
        raw_idx = scaled >>> SH;
        if (scaled < 0)
            idx = '0;
        else if (raw_idx > 32'(DEPTH - 1))
            idx = AW'(DEPTH - 1);
        else
            idx = AW'(raw_idx);
    end

    always_ff @(posedge clk) begin
        if (rst)
            ipv <= '0;
        else if (rd_en)
            ipv <= curve_rom[idx];
    end
endmodule

// File: rtl/boost_step_math.sv
module boost_step_math
    import boost_pkg::*;
#(
    parameter int VW   = VAL_W,
    parameter int DW   = DUTY_W,
    parameter int KCAP = K_CAP,
    parameter int KIND = K_IND,
    parameter int KRES = K_RES,
    parameter int SH   = COEF_SH
) (
    input  logic signed [VW-1:0] vpv,
    input  logic signed [VW-1:0] il,
    input  logic        [VW-1:0] ipv,
    input  logic        [VW-1:0] vbus,
    input  logic        [DW:0]   omd,
    output logic signed [VW-1:0] vpv_nxt,
    output logic signed [VW-1:0] il_nxt
);
    localparam int XW = 40;

    logic signed [XW-1:0] dcap, cap_term, res_term, vsw, vdrive, ind_term, il_sum;

    always_comb begin
        dcap     = XW'(signed'({1'b0, ipv})) - XW'(il);
        cap_term = (dcap * XW'(KCAP)) >>> SH;
        res_term = (XW'(il) * XW'(KRES)) >>> SH;
        vsw      = (XW'(signed'({1'b0, vbus})) * XW'(signed'({1'b0, omd}))) >>> DW;
        vdrive   = XW'(vpv) - vsw;
        ind_term = (vdrive * XW'(KIND)) >>> SH;
        il_sum   = res_term + ind_term;
        vpv_nxt  = VW'(XW'(vpv) + cap_term);
        il_nxt   = (il_sum < 0) ? '0 : VW'(il_sum);
    end
endmodule

// File: rtl/boost_avg_emu.sv
module boost_avg_emu
    import boost_pkg::*;
#(
    parameter int VW       = VAL_W,
    parameter int DW       = DUTY_W,
    parameter int DEPTH    = TBL_DEPTH,
    parameter int DUTY_MAX = DUTY_CEIL
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 step,
    input  logic [DW-1:0]        duty,
    input  logic [VW-1:0]        vbus,
    output logic signed [VW-1:0] vpv_o,
    output logic signed [VW-1:0] il_o,
    output logic signed [VW-1:0] ip_o,
    output logic                 step_done
);
    localparam int OMW   = DW + 1;
    localparam int DFULL = 1 << DW;
    localparam int XW    = 40;

    step_state_t state_q, state_d;

    logic [DW-1:0]        duty_q;
    logic [VW-1:0]        vbus_q;
    logic [VW-1:0]        ipv_q;
    logic [OMW-1:0]       omd;
    logic signed [VW-1:0] vpv_c, il_c, vpv_w, il_w;
    logic signed [XW-1:0] ip_w;

    assign omd  = OMW'(DFULL) - OMW'(duty_q);
    assign ip_w = (XW'(il_c) * XW'(signed'({1'b0, omd}))) >>> DW;

    boost_pv_lut #(.VW(VW), .DEPTH(DEPTH)) u_lut (
        .clk   (clk),
        .rst   (rst),
        .rd_en (state_q == S_LOAD),
        .vpv   (vpv_o),
        .ipv   (ipv_q)
    );

    boost_step_math #(.VW(VW), .DW(DW)) u_math (
        .vpv     (vpv_o),
        .il      (il_o),
        .ipv     (ipv_q),
        .vbus    (vbus_q),
        .omd     (omd),
        .vpv_nxt (vpv_w),
        .il_nxt  (il_w)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (step) state_d = S_LOAD;
            S_LOAD:   state_d = S_CALC;
            S_CALC:   state_d = S_COMMIT;
            S_COMMIT: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_q    <= '0;
            vbus_q    <= '0;
            vpv_c     <= '0;
            il_c      <= '0;
            vpv_o     <= '0;
            il_o      <= '0;
            ip_o      <= '0;
            step_done <= 1'b0;
        end else begin
            step_done <= 1'b0;
            unique case (state_q)
                S_IDLE: if (step) begin
                    duty_q <= (duty > DW'(DUTY_MAX)) ? DW'(DUTY_MAX) : duty;
                    vbus_q <= vbus;
                end
                S_LOAD: ;
                S_CALC: begin
                    vpv_c <= vpv_w;
                    il_c  <= il_w;
                end
                S_COMMIT: begin
                    vpv_o     <= vpv_c;
                    il_o      <= il_c;
                    ip_o      <= VW'(ip_w);
                    step_done <= 1'b1;
                end
            endcase
        end
    end

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        step_done |=> !step_done);
    // R2
    done_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(step_done) |-> $past(state_q) == S_COMMIT);
    // R2
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !step_done |-> ($stable(vpv_o) && $stable(il_o) && $stable(ip_o)));
    // R5
    il_nonneg_chk: assert property (@(posedge clk) disable iff (rst)
        il_o >= 0);
    // R6
    duty_ceil_chk: assert property (@(posedge clk) disable iff (rst)
        duty_q <= DW'(DUTY_MAX));
endmodule

// File: tb/boost_avg_emu_bench.sv
module boost_avg_emu_bench;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               step = 1'b0;
    logic [9:0]         duty = '0;
    logic [15:0]        vbus = '0;
    logic signed [15:0] vpv_o, il_o, ip_o;
    logic               step_done;

    int    n_chk = 0;
    int    n_bad = 0;
    string tag = "R3";
    bit    done_flag = 0;

    always #10 clk = ~clk;

    boost_avg_emu u_boost_avg_emu (
        .clk(clk), .rst(rst), .step(step), .duty(duty), .vbus(vbus),
        .vpv_o(vpv_o), .il_o(il_o), .ip_o(ip_o), .step_done(step_done)
    );

    // reference model state
    int     phase = 0;
    longint r_vpv = 0, r_il = 0, r_ip = 0, r_ipv = 0, c_vpv = 0, c_il = 0;
    longint l_duty = 0, l_vbus = 0;
    bit     r_done = 0;

    function automatic longint curve(longint n);
        if (n < 820) return 2260 - (133 * n) / 820;
        return (2127 * (1023 - n)) / 203;
    endfunction

    function automatic longint tbl_index(longint v);
        longint s;
        s = v * 7003;
        if (s < 0) return 0;
        if ((s >>> 16) > 1023) return 1023;
        return s >>> 16;
    endfunction

    always @(posedge clk) begin
        longint omd, a, b, vsw;
        if (rst) begin
            phase = 0; r_vpv = 0; r_il = 0; r_ip = 0; r_ipv = 0;
            c_vpv = 0; c_il = 0; l_duty = 0; l_vbus = 0; r_done = 0;
        end else begin
            r_done = 0;
            omd = 1024 - l_duty;
            case (phase)
                0: if (step) begin
                    l_duty = (duty > 972) ? 972 : longint'(duty);
                    l_vbus = longint'(vbus);
                    phase = 1;
                end
                1: begin r_ipv = curve(tbl_index(r_vpv)); phase = 2; end
                2: begin
                    c_vpv = r_vpv + (((r_ipv - r_il) * 5561) >>> 16);
                    vsw   = (l_vbus * omd) >>> 10;
                    a     = (r_il * 58863) >>> 16;
                    b     = ((r_vpv - vsw) * 16682) >>> 16;
                    c_il  = (a + b < 0) ? 0 : a + b;
                    phase = 3;
                end
                default: begin
                    r_vpv = c_vpv; r_il = c_il;
                    r_ip = (c_il * omd) >>> 10;
                    r_done = 1; phase = 0;
                end
            endcase
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            check({"R2 done ", tag}, longint'(step_done), longint'(r_done));
            check({"R3 R8 R9 vpv ", tag}, longint'(vpv_o), r_vpv);
            check({"R4 R5 R9 il ", tag}, longint'(il_o), r_il);
            check({"R7 ip ", tag}, longint'(ip_o), r_ip);
        end
    end

    task automatic one_step();
        @(negedge clk) step = 1'b1;
        @(negedge clk) step = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 vpv", longint'(vpv_o), 0);
        check("R1 il", longint'(il_o), 0);
        check("R1 ip", longint'(ip_o), 0);
        check("R1 done", longint'(step_done), 0);
        rst = 1'b0;
        vbus = 16'd48640; duty = 10'd860;
        one_step();
        // R8 first entry is 2260; R3 gives 191; R5 clamps the current
        check("R8 R3 first step vpv", longint'(vpv_o), 191);
        check("R5 first step il", longint'(il_o), 0);
        tag = "nominal";
        for (int i = 0; i < 150; i++) one_step();
        tag = "R6 duty above ceiling";
        duty = 10'd1023; vbus = 16'd20000;
        for (int i = 0; i < 100; i++) one_step();
        tag = "low bus";
        duty = 10'd0; vbus = 16'd0;
        for (int i = 0; i < 80; i++) one_step();
        tag = "R8 upper clamp";
        vbus = 16'd60000;
        for (int i = 0; i < 120; i++) one_step();
        tag = "R2 strobe held through busy";
        duty = 10'd500; vbus = 16'd30000;
        @(negedge clk) step = 1'b1;
        repeat (400) @(negedge clk);
        step = 1'b0;
        tag = "R2 strobe in busy state";
        for (int i = 0; i < 40; i++) begin
            @(negedge clk) step = 1'b1;
            @(negedge clk) step = 1'b0;
            @(negedge clk) step = 1'b1;
            @(negedge clk) step = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule